// File: doc/BRIEF.md
# Run-time Mode SPI Master

This block is a full-duplex serial peripheral master. It runs a single exchange of one word, 8 bits by default, each time the host raises `start` while the block is idle. The host chooses the clock polarity (`cpol`), the clock phase (`cpha`) and the bit order (`lsb_first`) for each exchange. These choices are captured when the exchange begins, so a single instance can serve peripherals that need different timing modes.

The serial clock toggles every `DIV` system clocks. Slave select is asserted one half-period before the first clock edge and released one half-period after the last one. While it sends each bit on `mosi`, the block samples `miso` on the same sampling edge. When the exchange ends, `done` pulses once and the received word is presented on `rx_byte`.

Top module: `spi_mode_master`

## Requirements
- R1: When idle and after reset, `ss_n` is 1, `busy` is 0, and `sclk` equals the present `cpol` input.
- R2: An accepted exchange holds `ss_n` low for exactly 17*DIV system clocks. The first `sclk` edge comes DIV clocks after `ss_n` falls, 16 edges follow DIV clocks apart, `ss_n` rises DIV clocks after the last edge, and `sclk` then rests at the latched polarity.
- R3: Mode number = 2*cpol + cpha. With cpha=0 the first bit is on `mosi` before edge 1, bits are sampled on odd edges and change on even edges. With cpha=1 bits change on odd edges and are sampled on even edges. The sampling edges rise in modes 0 and 3 and fall in modes 1 and 2.
- R4: `lsb_first`=0 sends and assembles bit 7 first. `lsb_first`=1 sends and assembles bit 0 first. This holds in all four modes.
- R5: Each exchange sends `tx_byte` on `mosi` and returns on `rx_byte` the 8 bits seen on `miso` at the sampling edges.
- R6: `done` is high for exactly one system clock. That clock is the one in which `ss_n` rises and `busy` falls, and `rx_byte` already holds the received word.
- R7: A `start` raised while `busy` is 1 has no effect. The running exchange and its data continue unchanged, and no extra exchange or `done` follows.
- R8: Changes to `cpol`, `cpha`, `lsb_first` or `tx_byte` during an exchange do not alter that exchange.
- R9: In mode 0 with MSB first, sending 0xA5 while the slave returns 0x3C gives `rx_byte` = 0x3C, and the slave receives 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one exchange (accepted only when idle) |
| tx_byte | input | W | Word to transmit |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on first edge of a bit, 1: on second |
| lsb_first | input | 1 | 1: bit 0 goes first, 0: bit W-1 goes first |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-clock pulse when `rx_byte` is valid |
| rx_byte | output | W | Last received word |
| ss_n | output | 1 | Slave select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |

## Verification
Every combination of the four modes and both bit orders is run against a set of word pairs. The pair 0xA5/0x3C is the mode 0 example. The non-palindromic 0xB5 and the single-bit words 0x01 and 0x80 reveal any bit reversal in either direction. All-zero and all-one words reveal stuck lines and off-by-one shifts. A behavioural slave, driven by its own copy of the mode, checks the direction of each sampling edge, the number of edges, and the lead and tail half-periods. Two further exchanges change the mode inputs and raise `start` again while the block is busy, to show that latching works and that the stray request is ignored.

// File: rtl/spi_mode_master.sv
module spi_mode_master #(
  parameter int DIV = 4,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         ss_n,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW = $clog2(2 * W + 1);
  localparam int BW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_END = CW'(DIV - 1);
  localparam logic [PW-1:0] PH_END  = PW'(2 * W);
  localparam logic [BW-1:0] TOP_BIT = BW'(W - 1);
  localparam logic [BW-1:0] NBITS   = BW'(W);

  logic          busy_r, done_r, ss_r, sclk_r, mosi_r;
  logic          cpol_l, cpha_l, lsb_l;
  logic [W-1:0]  tx_l, rx_sh, rx_q;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [BW-1:0] nb;
  logic          tick, samp, last;

  assign tick = busy_r && (cnt == CNT_END);
  assign last = (ph == PH_END);
  assign samp = (ph[0] == cpha_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
      ss_r   <= 1'b1;
      sclk_r <= 1'b0;
      mosi_r <= 1'b0;
      cpol_l <= 1'b0;
      cpha_l <= 1'b0;
      lsb_l  <= 1'b0;
      tx_l   <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
      cnt    <= '0;
      ph     <= '0;
      nb     <= '0;
    end else begin
      done_r <= 1'b0;
      if (!busy_r) begin
        if (start) begin
          busy_r <= 1'b1;
          ss_r   <= 1'b0;
          sclk_r <= cpol;
          cpol_l <= cpol;
          cpha_l <= cpha;
          lsb_l  <= lsb_first;
          tx_l   <= tx_byte;
          rx_sh  <= '0;
          cnt    <= '0;
          ph     <= '0;
          if (cpha) begin
            mosi_r <= 1'b0;
            nb     <= '0;
          end else begin
            mosi_r <= lsb_first ? tx_byte[0] : tx_byte[W-1];
            nb     <= BW'(1);
          end
        end
      end else begin
        cnt <= tick ? '0 : cnt + CW'(1);
        if (tick) begin
          if (last) begin
            busy_r <= 1'b0;
            ss_r   <= 1'b1;
            done_r <= 1'b1;
            rx_q   <= rx_sh;
          end else begin
            ph     <= ph + PW'(1);
            sclk_r <= ~sclk_r;
            if (samp) begin
              rx_sh <= lsb_l ? {miso, rx_sh[W-1:1]} : {rx_sh[W-2:0], miso};
            end else if (nb < NBITS) begin
              mosi_r <= lsb_l ? tx_l[nb] : tx_l[TOP_BIT - nb];
              nb     <= nb + BW'(1);
            end
          end
        end
      end
    end
  end

  assign busy    = busy_r;
  assign done    = done_r;
  assign rx_byte = rx_q;
  assign ss_n    = ss_r;
  assign sclk    = busy_r ? sclk_r : cpol;
  assign mosi    = mosi_r;

  a_r2_all_bits_sent: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (nb == NBITS));
  a_r2_clock_rests: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (sclk_r == cpol_l));
  a_r3_data_held_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !last && samp) |=> $stable(mosi_r));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |=> !done_r);
  a_r6_end_together: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (ss_n && !busy_r));
  a_r8_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && $past(busy_r)) |-> $stable({cpol_l, cpha_l, lsb_l, tx_l}));
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && !tick) |=> (busy_r && $stable(ph)));
endmodule

// File: tb/spi_mode_master_test.sv
module spi_mode_master_test;
  localparam int DIV = 3;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic busy, done, ss_n, sclk, mosi;
  logic miso = 1'b0;
  logic [7:0] rx_byte;

  always #5 clk = ~clk;

  spi_mode_master #(.DIV(DIV), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  int compared = 0, mismatched = 0;
  int cyc = 0;
  bit finished = 0;

  always @(negedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic m_cpol = 0, m_cpha = 0, m_lsb = 0;
  logic [7:0] stx = 8'h00, srx;
  int ecnt, sbit, scnt, t_ss, t_first, t_last, t_end, direrr;

  function automatic logic bo(input logic [7:0] v, input int k, input logic lsb);
    return lsb ? v[k] : v[7-k];
  endfunction

  always @(negedge ss_n) begin
    ecnt = 0; sbit = 0; scnt = 0; srx = 8'h00; direrr = 0;
    t_ss = cyc;
    if (!m_cpha) begin miso = bo(stx, 0, m_lsb); sbit = 1; end
  end

  always @(posedge ss_n) t_end = cyc;

  always @(sclk) begin
    if (ss_n === 1'b0) begin
      ecnt++;
      if (ecnt == 1) t_first = cyc;
      t_last = cyc;
      if (((ecnt % 2) == 1) == (m_cpha == 1'b0)) begin
        if (sclk !== (m_cpol == m_cpha)) direrr++;
        if (scnt < 8) begin
          if (m_lsb) srx[scnt] = mosi; else srx[7-scnt] = mosi;
        end
        scnt++;
      end else if (sbit < 8) begin
        miso = bo(stx, sbit, m_lsb);
        sbit++;
      end
    end
  end

  task automatic xfer(input int mode, input logic lsb, input logic [7:0] t,
                      input logic [7:0] s, input bit midchange, input bit midstart);
    int dones = 0, donew = 0, prevd = 0;
    logic [7:0] got = 8'h00;
    int sclk_end = 0, busy_end = 1;
    @(negedge clk);
    cpol = mode[1]; cpha = mode[0]; lsb_first = lsb; tx_byte = t;
    m_cpol = mode[1]; m_cpha = mode[0]; m_lsb = lsb; stx = s;
    #1;
    chk("R1 idle sclk", sclk, mode[1]);
    chk("R1 idle ss_n", ss_n, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 17 * DIV + 12; n++) begin
      if (midchange && n == 4) begin cpol = ~cpol; cpha = ~cpha; lsb_first = ~lsb_first; tx_byte = ~t; end
      if (midchange && n == 20) begin cpol = mode[1]; cpha = mode[0]; lsb_first = lsb; end
      if (midstart && n == 7) begin start = 1'b1; tx_byte = ~t; end
      if (midstart && n == 8) start = 1'b0;
      @(negedge clk);
      if (done) begin
        dones++; got = rx_byte; sclk_end = sclk; busy_end = busy;
        if (prevd) donew++;
      end
      prevd = done;
    end
    tx_byte = t;
    chk($sformatf("R5 rx mode%0d lsb%0d", mode, lsb), got, s);
    chk($sformatf("R4 slave got mode%0d lsb%0d", mode, lsb), srx, t);
    chk("R2 edge count", ecnt, 16);
    chk("R2 ss low clocks", t_end - t_ss, 17 * DIV);
    chk("R2 lead half-period", t_first - t_ss, DIV);
    chk("R2 tail half-period", t_end - t_last, DIV);
    chk("R2 sclk rests at cpol", sclk_end, mode[1]);
    chk($sformatf("R3 sample edge direction mode%0d", mode), direrr, 0);
    chk("R6 one done pulse", dones, 1);
    chk("R6 done width", donew, 0);
    chk("R6 busy low at done", busy_end, 0);
    if (midstart) chk("R7 stray start ignored", ss_n, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  logic [7:0] pt [7] = '{8'hA5, 8'hB5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A};
  logic [7:0] ps [7] = '{8'h3C, 8'hAD, 8'hFF, 8'h00, 8'h80, 8'h01, 8'hC3};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ss_n", ss_n, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset sclk", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cpol = 1'b1; #1;
    chk("R1 idle sclk follows cpol", sclk, 1);
    cpol = 1'b0;
    xfer(0, 1'b0, 8'hA5, 8'h3C, 0, 0);
    chk("R9 example rx", rx_byte, 8'h3C);
    chk("R9 example slave", srx, 8'hA5);
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 7; p++)
          xfer(m, l[0], pt[p], ps[p], 0, 0);
    xfer(3, 1'b1, 8'hB5, 8'h2E, 1, 0);
    chk("R8 mid-change ignored rx", rx_byte, 8'h2E);
    xfer(1, 1'b0, 8'h96, 8'h4D, 0, 1);
    chk("R7 data unchanged by stray start", srx, 8'h96);
    repeat (4 * DIV) @(negedge clk);
    chk("R7 no extra exchange", busy, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule